// File: doc/BRIEF.md
# Two-Channel Disk Controller Mode Switch

This block holds the small part of a two-channel disk controller's PCI configuration space that picks how the channels are reached. Software writes the programming-interface byte, and the block moves both channels together between two modes. In compatibility mode the channels answer at the fixed ISA-era I/O ports. In native mode the channels are reached through base address registers that software programs.

The configuration port accepts a dword address, byte enables and write data. Reads are combinational from the address. After a write that reaches the programming-interface byte, the block re-evaluates the mode. It then sets the base address registers, the advertised interrupt pin and four legacy decode enables to match.

A separate I/O address input is compared against the four fixed compatibility windows. The block reports a hit for each window that is enabled.

Top module: `ide_mode_cfg`

## Requirements
- R1: After reset the programming-interface byte is 0x8A, all four legacy enables are 1, the interrupt pin reads 0, the interrupt line reads 0x0E, and BAR0 to BAR3 read 0.
- R2: A write to the programming-interface byte changes only bits 0 and 2 of it. The other bits keep their reset values.
- R3: When a write leaves the low nibble of the programming-interface byte at 0xA, compatibility mode is entered. All four legacy enables go to 1, BAR0 to BAR3 are cleared to 0, and the interrupt pin becomes 0.
- R4: When a write leaves the low nibble at 0xF, native mode is entered. All four legacy enables go to 0 and the interrupt pin becomes 1. The BARs keep their present values and are not loaded with any default.
- R5: A write that leaves the low nibble at any other value (0xB or 0xE) leaves the mode, the BARs and the interrupt pin unchanged.
- R6: A configuration write that is not to dword 2 with byte enable 1 set leaves the programming-interface byte and the mode unchanged.
- R7: A mode change is applied at the clock edge that accepts the write. The legacy enables and hits show the new mode from the next cycle, and not before that edge.
- R8: BAR0 to BAR3 sit at dwords 4 to 7. In native mode a write merges the enabled bytes and stores bits [1:0] as 01. In compatibility mode BAR writes are ignored and BAR reads return 0.
- R9: The legacy_hit bits are: bit 0 for 0x1F0 to 0x1F7, bit 1 for 0x3F6, bit 2 for 0x170 to 0x177, and bit 3 for 0x376. A bit is 1 only when its enable is set and io_addr lies inside its window.
- R10: Dword 2 reads {0x0101, programming-interface byte, 0x00}. Dword 15 reads {0x0000, interrupt pin, interrupt line}. The interrupt line is read-only at 0x0E, and every other dword reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| io_addr | input | 16 | I/O address to decode |
| legacy_en | output | 4 | Decode enable of each compatibility window |
| legacy_hit | output | 4 | Hit of each enabled compatibility window |

## Verification
Several properties are checked on every cycle:
- The fixed bits of the programming-interface byte never move.
- The interrupt pin always matches the mode.
- The BARs stay at zero while in compatibility mode.
- A hit never appears in native mode.
- A mode flip happens only with a 0xA or 0xF nibble.
- A write that misses the byte leaves it stable.

Other behaviours can only be shown by the bench scenarios, because they depend on the value history that software builds up:
- BARs written in native mode survive a 0xB or 0xE write.
- BARs come back as zero after a round trip through compatibility mode.
- The window edges decode exactly.
- The hit changes at the accepting edge and not before it.

// File: rtl/ide_mode_cfg.sv
module ide_mode_cfg #(
  parameter int unsigned IO_AW        = 16,
  parameter logic [7:0]  PROGIF_RST   = 8'h8A,
  parameter logic [7:0]  PROGIF_WMASK = 8'h05,
  parameter logic [7:0]  IRQ_LINE_VAL = 8'h0E,
  parameter logic [15:0] CLASS_SUB    = 16'h0101,
  parameter int unsigned PRI_CMD_BASE = 32'h1F0,
  parameter int unsigned PRI_CTL_BASE = 32'h3F6,
  parameter int unsigned SEC_CMD_BASE = 32'h170,
  parameter int unsigned SEC_CTL_BASE = 32'h376,
  parameter int unsigned CMD_SPAN     = 8,
  parameter int unsigned CTL_SPAN     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [5:0]       cfg_addr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [IO_AW-1:0] io_addr,
  output logic [3:0]       legacy_en,
  output logic [3:0]       legacy_hit
);
  localparam int unsigned NUM_BARS  = 4;
  localparam int unsigned NUM_WIN   = 4;
  localparam logic [5:0]  DW_CLASS  = 6'd2;
  localparam logic [5:0]  DW_BAR0   = 6'd4;
  localparam logic [5:0]  DW_IRQ    = 6'd15;
  localparam logic [3:0]  NIB_LEG   = 4'hA;
  localparam logic [3:0]  NIB_NAT   = 4'hF;
  localparam logic        RST_LEG   = (PROGIF_RST[3:0] != NIB_NAT);
  localparam int unsigned WIN_BASE [NUM_WIN] = '{PRI_CMD_BASE, PRI_CTL_BASE, SEC_CMD_BASE, SEC_CTL_BASE};
  localparam int unsigned WIN_SPAN [NUM_WIN] = '{CMD_SPAN, CTL_SPAN, CMD_SPAN, CTL_SPAN};

  logic [7:0]  progif_q;
  logic        legacy_q;
  logic        irq_pin_q;
  logic [31:0] bar_q [NUM_BARS];

  wire       prog_wr    = cfg_wr && (cfg_addr == DW_CLASS) && cfg_be[1];
  wire [7:0] progif_nxt = (progif_q & ~PROGIF_WMASK) | (cfg_wdata[15:8] & PROGIF_WMASK);
  wire       go_legacy  = prog_wr && (progif_nxt[3:0] == NIB_LEG);
  wire       go_native  = prog_wr && (progif_nxt[3:0] == NIB_NAT);

  function automatic logic [31:0] bar_merge(input logic [31:0] old, input logic [31:0] wd,
                                            input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : old[b*8 +: 8];
    r[1:0] = 2'b01;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progif_q  <= PROGIF_RST;
      legacy_q  <= RST_LEG;
      irq_pin_q <= !RST_LEG;
    end else begin
      if (prog_wr) progif_q <= progif_nxt;
      if (go_legacy) begin
        legacy_q  <= 1'b1;
        irq_pin_q <= 1'b0;
      end else if (go_native) begin
        legacy_q  <= 1'b0;
        irq_pin_q <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    always_ff @(posedge clk) begin
      if (!rst_n || go_legacy)
        bar_q[i] <= '0;
      else if (cfg_wr && !legacy_q && (cfg_addr == DW_BAR0 + 6'(i)))
        bar_q[i] <= bar_merge(bar_q[i], cfg_wdata, cfg_be);
    end
    AST_LEGACY_BAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_q |-> (bar_q[i] == 32'h0));  // R3
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == DW_CLASS)
      cfg_rdata = {CLASS_SUB, progif_q, 8'h00};
    else if (cfg_addr == DW_IRQ)
      cfg_rdata = {16'h0000, 7'h00, irq_pin_q, IRQ_LINE_VAL};
    else if (cfg_addr >= DW_BAR0 && cfg_addr < DW_BAR0 + 6'(NUM_BARS) && !legacy_q)
      cfg_rdata = bar_q[cfg_addr[1:0]];
  end

  assign legacy_en = {NUM_WIN{legacy_q}};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    wire [31:0] a32 = 32'(io_addr);
    assign legacy_hit[w] = legacy_en[w] && (a32 >= WIN_BASE[w]) && (a32 < WIN_BASE[w] + WIN_SPAN[w]);
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (progif_q & ~PROGIF_WMASK) == (PROGIF_RST & ~PROGIF_WMASK));  // R2
  AST_PIN_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin_q == !legacy_q);  // R4
  AST_MODE_FLIP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(legacy_q) |-> (progif_q[3:0] == NIB_LEG || progif_q[3:0] == NIB_NAT));  // R5
  AST_NONCOVER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == DW_CLASS && cfg_be[1]) |=> $stable(progif_q));  // R6
  AST_NATIVE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == DW_CLASS && cfg_be[1] &&
     ((cfg_wdata[15:8] & PROGIF_WMASK) | (progif_q & ~PROGIF_WMASK)) == (PROGIF_RST | PROGIF_WMASK))
    |=> (legacy_en == 4'h0));  // R7
  AST_NO_HIT_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_q |-> (legacy_hit == 4'h0));  // R9
endmodule

// File: tb/ide_mode_cfg_bench.sv
`timescale 1ns/1ps
module ide_mode_cfg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic [3:0]  legacy_en;
  logic [3:0]  legacy_hit;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  m_prog;
  logic        m_leg;
  logic        m_pin;
  logic [31:0] m_bar [4];

  always #10 clk = ~clk;

  ide_mode_cfg u_ide_mode_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .legacy_en(legacy_en), .legacy_hit(legacy_hit));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int dw);
    if (dw == 2) return {16'h0101, m_prog, 8'h00};
    if (dw == 15) return {23'h0, m_pin, 8'h0E};
    if (dw >= 4 && dw <= 7) return m_leg ? 32'h0 : m_bar[dw-4];
    return 32'h0;
  endfunction

  function automatic logic [3:0] exp_hit(input logic [15:0] a);
    logic [3:0] h;
    h[0] = (a >= 16'h1F0 && a <= 16'h1F7);
    h[1] = (a == 16'h3F6);
    h[2] = (a >= 16'h170 && a <= 16'h177);
    h[3] = (a == 16'h376);
    return m_leg ? h : 4'h0;
  endfunction

  task automatic model_reset();
    m_prog = 8'h8A; m_leg = 1'b1; m_pin = 1'b0;
    for (int i = 0; i < 4; i++) m_bar[i] = 32'h0;
  endtask

  task automatic model_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    if (a == 6'd2 && be[1]) begin
      m_prog = (m_prog & 8'hFA) | (d[15:8] & 8'h05);
      if (m_prog[3:0] == 4'hA) begin
        m_leg = 1'b1; m_pin = 1'b0;
        for (int i = 0; i < 4; i++) m_bar[i] = 32'h0;
      end else if (m_prog[3:0] == 4'hF) begin
        m_leg = 1'b0; m_pin = 1'b1;
      end
    end else if (a >= 6'd4 && a <= 6'd7 && !m_leg) begin
      for (int b = 0; b < 4; b++) if (be[b]) m_bar[a-4][b*8 +: 8] = d[b*8 +: 8];
      m_bar[a-4][1:0] = 2'b01;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(a, be, d);
  endtask

  task automatic rd_chk(input string req, input int dw);
    cfg_addr = 6'(dw);
    #1;
    chk(req, cfg_rdata, exp_rd(dw));
  endtask

  task automatic hit_chk(input string req, input logic [15:0] a);
    io_addr = a;
    #1;
    chk(req, {28'h0, legacy_hit}, {28'h0, exp_hit(a)});
  endtask

  task automatic all_chk(input string req);
    for (int dw = 0; dw < 16; dw++) rd_chk(req, dw);
    chk(req, {28'h0, legacy_en}, {28'h0, {4{m_leg}}});
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] bases [4];
    void'($urandom(32'd20231024));
    bases = '{16'h1F0, 16'h3F6, 16'h170, 16'h376};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    all_chk("R1");
    chk("R1", {24'h0, cfg_rdata[15:8]}, 32'h0);
    hit_chk("R1", 16'h1F0);

    // R9 window boundaries in compatibility mode
    foreach (bases[k]) for (int o = -1; o <= 8; o++) hit_chk("R9", bases[k] + 16'(o));

    // R2 mask, R4 native, R7 timing
    io_addr = 16'h1F0;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 6'd2; cfg_be = 4'b0010; cfg_wdata = 32'h0000FF00;
    #1;
    chk("R7", {31'h0, legacy_hit[0]}, 32'h1);
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(6'd2, 4'b0010, 32'h0000FF00);
    chk("R7", {31'h0, legacy_hit[0]}, 32'h0);
    chk("R2", {24'h0, m_prog}, 32'h8F);
    all_chk("R4");
    hit_chk("R9", 16'h376);

    // R8 native BAR writes
    wr(6'd4, 4'b0011, 32'hFFFFFFFF);
    chk("R8", exp_rd(4), 32'h0000FFFD);
    wr(6'd5, 4'b1111, 32'h0000C002);
    wr(6'd6, 4'b1111, 32'h00001234);
    wr(6'd7, 4'b1100, 32'hABCD0000);
    all_chk("R8");

    // R5 other nibbles hold mode and BARs
    wr(6'd2, 4'b0010, 32'h00000100);
    chk("R5", {24'h0, m_prog}, 32'h8B);
    all_chk("R5");
    wr(6'd2, 4'b0010, 32'h00000400);
    chk("R5", {24'h0, m_prog}, 32'h8E);
    all_chk("R5");

    // R6 write to dword 2 without byte 1, and to other dwords
    wr(6'd2, 4'b1101, 32'hFFFF00FF);
    all_chk("R6");
    wr(6'd3, 4'b1111, 32'h00000A00);
    all_chk("R6");

    // R3 back to compatibility: BARs cleared, pin 0
    wr(6'd2, 4'b0010, 32'h00000000);
    all_chk("R3");
    hit_chk("R3", 16'h177);
    // R8 BAR writes ignored in compatibility mode
    wr(6'd4, 4'b1111, 32'h12345678);
    all_chk("R8");
    // R4 BARs not restored on native entry
    wr(6'd2, 4'b0010, 32'h00000500);
    chk("R4", exp_rd(4), 32'h0);
    all_chk("R4");

    // R10 line read-only, unimplemented reads zero
    wr(6'd15, 4'b1111, 32'hFFFFFFFF);
    all_chk("R10");
    rd_chk("R10", 63);
    rd_chk("R10", 40);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic [15:0] ia;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 3) a = 6'd2;
      else if (sel < 8) a = 6'(4 + $urandom_range(0, 3));
      else a = 6'($urandom_range(0, 63));
      d = $urandom();
      wr(a, 4'($urandom_range(0, 15)), d);
      all_chk("R8");
      rd_chk("R10", int'($urandom_range(16, 63)));
      ia = bases[$urandom_range(0, 3)] + 16'($urandom_range(0, 10)) - 16'd1;
      hit_chk("R9", ia);
    end

    // R1 reset again restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    all_chk("R1");

    done = 1'b1;
    summary();
  end
endmodule